// File: doc/BRIEF.md
# Bubble-Free Timing-Error Recovery Pipeline

This block is a four-stage pipeline (front, decode, execute, memory) followed by a dummy slack stage. It recovers from a late-detected timing error in the execute stage without losing a retire slot. The block runs on a fast clock at twice the pipeline rate, so every pipeline cycle has a full edge and a half edge. The `beat` output is high in the fast cycle that ends on a full edge. Items are accepted on full edges, and one result leaves on the retire port per full edge.

The execute result enters the memory stage on a full edge. A shadow copy of that result is kept beside it. On the following half edge the two are compared. On a mismatch the shadow value replaces the stored one. The memory stage's next capture is then pushed back by half a cycle, so the corrected item gets one and a half cycles there. The item behind it is parked in a side stage that runs in parallel. The corrected item enters the dummy stage on the late half edge, and the parked item follows on the next full edge. The dummy stage absorbs the borrowed half cycle, so the output cadence and latency are unchanged.

If a second mismatch is found in the side stage while recovery is running, the block falls back to a single bubble. The intake stalls for one cycle and the parked item moves into the memory stage for a full cycle.

Top module: `slack_recovery_pipe`

## Requirements
- R1: During and right after reset, `ret_valid` and `busy` are 0 and `in_ready` is 1.
- R2: An item x accepted on a full edge (`in_valid` and `in_ready` high in a `beat` cycle) retires as rotl1((3*x + 5) mod 2^16), where rotl1 rotates left by one bit. Items retire in acceptance order. Without errors, the result is on `ret_data` after the fifth full edge following acceptance.
- R3: `ret_valid` and `ret_data` change only on full edges, so at most one item retires per pipeline cycle.
- R4: `fault_in`, sampled on a full edge while execute holds an item, XORs the value entering the memory (or side) stage with 1. The mismatch is detected on the next half edge, and the shadow value replaces the stored value. The retired data is always the correct value.
- R5: A single error causes no empty retire slot. With a continuous input stream, the output stays valid on every pipeline cycle.
- R6: During recovery, the following item waits in the side stage and enters the dummy stage one half cycle after the corrected item. Retire order is kept.
- R7: `busy` rises on the half edge of detection and stays high for exactly three fast cycles. A new error captured on the full edge that ends recovery starts a fresh recovery.
- R8: A fault on the item being parked in the side stage falls back to one bubble. `in_ready` is low for one beat, one retire slot is empty, and the data stays correct.
- R9: `fault_in` has no effect when execute holds no item or when the intake is stalled. It does not raise `busy` and does not alter any retired value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the pipeline rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Item present, sampled on full edges |
| in_data | input | DW | Item value |
| in_ready | output | 1 | Low while the intake is stalled for a bubble |
| fault_in | input | 1 | Timing-fault strobe for the execute result, sampled on full edges |
| beat | output | 1 | High in the fast cycle that ends on a full edge |
| ret_valid | output | 1 | Retired item present |
| ret_data | output | DW | Retired item value |
| busy | output | 1 | Recovery in progress |

## Verification
On every cycle, the assertions check how recovery is sequenced. Detection happens only on half edges and raises `busy`. A delayed capture always follows the hold, and the side stage always merges or falls back to a bubble on the next edge. `busy` never exceeds three fast cycles, a stall never occurs outside recovery, and the retire port never changes on a half edge. Only the bench scenarios can show the following: that retired values are correct and in order after single, back-to-back, nested and ignored faults, that no slot is lost on a single error, and where exactly the bubble lands.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // normal flow
    ST_HOLD,   // memory capture deferred, next item steered aside
    ST_MERGE,  // late capture into dummy, side item checked
    ST_JOIN,   // side item merges into dummy
    ST_BUB     // fallback: bubble into dummy, intake stalled
  } rec_st_e;
endpackage

// File: rtl/srp_phase.sv
module srp_phase (
  input  logic clk,
  input  logic rst_n,
  output logic beat
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign beat = ~half_q;
endmodule

// File: rtl/srp_mismatch.sv
module srp_mismatch #(
  parameter int DW = 16
) (
  input  logic          en,
  input  logic          vld,
  input  logic [DW-1:0] live,
  input  logic [DW-1:0] shadow,
  output logic          hit
);
  assign hit = en & vld & (live != shadow);
endmodule

// File: rtl/srp_recov_ctrl.sv
module srp_recov_ctrl
  import srp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    beat,
  input  logic    mm_hit,
  input  logic    sd_hit,
  output rec_st_e st
);
  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE:  if (!beat && mm_hit) st <= ST_HOLD;
        ST_HOLD:  if (beat) st <= ST_MERGE;
        ST_MERGE: if (!beat) st <= sd_hit ? ST_BUB : ST_JOIN;
        ST_JOIN:  if (beat) st <= ST_IDLE;
        ST_BUB:   if (beat) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slack_recovery_pipe.sv
module slack_recovery_pipe
  import srp_pkg::*;
#(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] EX_ADD  = DW'(5),
  parameter logic [DW-1:0] CORRUPT = DW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          fault_in,
  output logic          beat,
  output logic          ret_valid,
  output logic [DW-1:0] ret_data,
  output logic          busy
);
  localparam int NPROBE = 2;  // probe 0: memory stage, probe 1: side stage

  function automatic logic [DW-1:0] exe_fn(input logic [DW-1:0] x);
    return x * DW'(3) + EX_ADD;
  endfunction

  function automatic logic [DW-1:0] mem_fn(input logic [DW-1:0] y);
    return {y[DW-2:0], y[DW-1]};
  endfunction

  rec_st_e st;

  logic          fr_v, dc_v, ex_v, mm_v, sd_v, dm_v;
  logic [DW-1:0] fr_d, dc_d, ex_d, mm_d, sd_d, dm_d;
  logic [DW-1:0] mm_sh, sd_sh;

  logic [NPROBE-1:0] probe_en, probe_v, probe_hit;
  logic [DW-1:0]     probe_live [NPROBE];
  logic [DW-1:0]     probe_sh   [NPROBE];

  // Named internal events, brought out for the checker
  logic ev_detect, ev_hold, ev_late, ev_join, ev_bubble;

  logic          adv_up;
  logic [DW-1:0] ex_res, ex_bad;

  srp_phase u_phase (.clk(clk), .rst_n(rst_n), .beat(beat));

  always_comb begin
    probe_en[0]   = ~beat & (st == ST_IDLE);
    probe_v[0]    = mm_v;
    probe_live[0] = mm_d;
    probe_sh[0]   = mm_sh;
    probe_en[1]   = ~beat & (st == ST_MERGE);
    probe_v[1]    = sd_v;
    probe_live[1] = sd_d;
    probe_sh[1]   = sd_sh;
  end

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    srp_mismatch #(.DW(DW)) u_cmp (
      .en(probe_en[g]), .vld(probe_v[g]), .live(probe_live[g]),
      .shadow(probe_sh[g]), .hit(probe_hit[g])
    );
  end

  srp_recov_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .mm_hit(probe_hit[0]), .sd_hit(probe_hit[1]), .st(st)
  );

  assign ev_detect = probe_hit[0];
  assign ev_hold   = beat & (st == ST_HOLD);
  assign ev_late   = ~beat & (st == ST_MERGE);
  assign ev_join   = beat & (st == ST_JOIN);
  assign ev_bubble = beat & (st == ST_BUB);

  assign in_ready = (st != ST_BUB);
  assign busy     = (st != ST_IDLE);
  assign adv_up   = beat & in_ready;
  assign ex_res   = exe_fn(ex_d);
  assign ex_bad   = ex_res ^ ((fault_in & ex_v) ? CORRUPT : '0);

  // Front, decode, execute: advance on full edges unless stalled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_v <= 1'b0; dc_v <= 1'b0; ex_v <= 1'b0;
      fr_d <= '0;   dc_d <= '0;   ex_d <= '0;
    end else if (adv_up) begin
      fr_v <= in_valid; fr_d <= in_data;
      dc_v <= fr_v;     dc_d <= fr_d;
      ex_v <= dc_v;     ex_d <= dc_d;
    end
  end

  // Memory, side, dummy and retire registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mm_v <= 1'b0; mm_d <= '0; mm_sh <= '0;
      sd_v <= 1'b0; sd_d <= '0; sd_sh <= '0;
      dm_v <= 1'b0; dm_d <= '0;
      ret_valid <= 1'b0; ret_data <= '0;
    end else if (beat) begin
      ret_valid <= dm_v;
      ret_data  <= dm_d;
      unique case (st)
        ST_IDLE, ST_JOIN: begin
          mm_v  <= ex_v;
          mm_d  <= ex_bad;
          mm_sh <= ex_res;
          if (st == ST_JOIN) begin
            dm_v <= sd_v; dm_d <= mem_fn(sd_d);
            sd_v <= 1'b0;
          end else begin
            dm_v <= mm_v; dm_d <= mem_fn(mm_d);
          end
        end
        ST_HOLD: begin
          sd_v  <= ex_v;
          sd_d  <= ex_bad;
          sd_sh <= ex_res;
        end
        ST_BUB: begin
          dm_v  <= 1'b0;
          mm_v  <= sd_v;
          mm_d  <= sd_d;
          mm_sh <= sd_d;
          sd_v  <= 1'b0;
        end
        default: ;
      endcase
    end else begin
      if (probe_hit[0]) mm_d <= mm_sh;
      if (st == ST_MERGE) begin
        dm_v <= mm_v;
        dm_d <= mem_fn(mm_d);
        if (probe_hit[1]) sd_d <= sd_sh;
      end
    end
  end
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat,
  input logic          busy,
  input logic          in_ready,
  input logic          ret_valid,
  input logic [DW-1:0] ret_data,
  input logic          ev_detect,
  input logic          ev_hold,
  input logic          ev_late,
  input logic          ev_join,
  input logic          ev_bubble
);
  assert_det_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detect |-> !beat);

  assert_det_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_detect |=> busy);

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(busy, 2) |=> !busy);

  assert_late_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> ev_late);

  assert_side_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late |=> (ev_join || ev_bubble));

  assert_stall_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> busy);

  assert_ret_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(beat) |-> ($stable(ret_valid) && $stable(ret_data)));
endmodule

bind slack_recovery_pipe srp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .beat(beat), .busy(busy), .in_ready(in_ready),
  .ret_valid(ret_valid), .ret_data(ret_data),
  .ev_detect(ev_detect), .ev_hold(ev_hold), .ev_late(ev_late),
  .ev_join(ev_join), .ev_bubble(ev_bubble)
);

// File: tb/sim_slack_recovery_pipe.sv
`timescale 1ns/1ps
module sim_slack_recovery_pipe;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          fault_in = 1'b0;
  logic          in_ready, beat, ret_valid, busy;
  logic [DW-1:0] ret_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  slack_recovery_pipe #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fault_in(fault_in), .beat(beat),
    .ret_valid(ret_valid), .ret_data(ret_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // Expected result restated: triple plus five, wrap, rotate left one bit
  function automatic int model(input int x);
    int t;
    t = (x * 3 + 5) % 65536;
    return ((t * 2) % 65536) + (t / 32768);
  endfunction

  function automatic bit is_fault_beat(input int b);
    return b == 1 || b == 20 || b == 30 || b == 32 || b == 40 || b == 41 ||
           b == 60 || b == 61 || b == 62;
  endfunction

  function automatic bit exp_busy(input int b);
    return b == 21 || b == 22 || (b >= 31 && b <= 34) || b == 41 || b == 42 ||
           b == 61 || b == 62;
  endfunction

  int exp_q[$];

  initial begin
    int b;
    int x;
    b = 0;
    x = 0;
    repeat (3) @(negedge clk);
    chk(ret_valid == 1'b0, "R1 ret_valid in reset", int'(ret_valid), 0);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    while (b <= 100) begin
      if (beat) begin
        if (b == 0)
          chk(ret_valid == 1'b0, "R1 ret_valid after reset", int'(ret_valid), 0);
        // R3/R5/R8: one retire per pipeline cycle, the bubble only where predicted
        if (b >= 6 && b < 80) begin
          bit ev;
          ev = !(b == 44 || b == 64);
          chk(ret_valid == ev, (ev ? "R5 retire slot filled" : "R8 bubble slot"),
              int'(ret_valid), int'(ev));
        end
        // R2/R4/R6: value and order against queue
        if (ret_valid) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected retire", int'(ret_data), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(ret_data) == e, "R2 R4 R6 retired value/order", int'(ret_data), e);
          end
        end
        // R7/R9: recovery busy window, ignored faults raise nothing
        chk(busy == exp_busy(b), "R7 R9 busy window", int'(busy), int'(exp_busy(b)));
        // R8: intake stall in the bubble beat only
        begin
          bit er;
          er = !(b == 42 || b == 62);
          chk(in_ready == er, "R8 in_ready", int'(in_ready), int'(er));
        end
        // drive this beat's inputs
        in_valid = (b < 85);
        in_data  = DW'(x);
        fault_in = is_fault_beat(b);
        if (in_valid && in_ready) begin
          exp_q.push_back(model(x));
          x++;
        end
        b++;
      end else begin
        fault_in = 1'b0;
      end
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R2 all accepted items retired", exp_q.size(), 0);
    chk(x == 83, "R8 accepted count with two stalls", x, 83);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule